// File: doc/BRIEF.md
# Bus-Edge Capture/Compare Timer

A free-running counter advances on a slow timing enable, such as a 5 MHz tick derived from the system clock. Each falling edge on a single-wire bus stores the live count in a capture register. The bus input is first re-timed through a short flop chain. Firmware reads the captured count to measure how long the bus stays low. It can also program a compare value so that a match against the next capture raises an interrupt. This lets firmware time the symbols it holds on the bus itself (sync, zero and one differ only in how long the line stays low).

The match is tested once, in the cycle after each new capture. It sets a sticky interrupt flag, which firmware clears with a one-cycle clear strobe. When the interrupt enable is off, captures still happen and no flag is raised. A small register port gives write access to the compare value and the enable. The same port reads back the compare value, the enable, the captured count and the live count.

Top module: `edge_capture_timer`

## Requirements
- R1: After a reset cycle (rst_n low at a clock edge), the captured count, the compare value, the enable and irq_o are all zero, and the synchronizer holds the idle-high bus level.
- R2: The live count (read at address 3) goes up by exactly one on each clock edge where tick_i is high, holds otherwise, and wraps from 0xFFFF to 0x0000.
- R3: A high-to-low change on bus_i loads the live count into capture_o. The count loaded is the one present two clock edges after bus_i is first sampled low, and it appears after the third edge.
- R4: Rising edges, a bus held low and a bus held high never change capture_o.
- R5: A write (wr_en_i high) to address 0 stores wr_data_i as the compare value. A write to address 1 stores wr_data_i bit 0 as the interrupt enable. Reads at address 0 and 1 return them, with the enable in bit 0 and zeros above it.
- R6: With the enable set, a capture whose value equals the compare value sets irq_o one clock after capture_o updates.
- R7: irq_o stays high until a clock edge with irq_clr_i high clears it. If a new match and a clear fall on the same edge, the flag ends up set.
- R8: With the enable clear, matching captures never set irq_o, but capture_o keeps loading on falling edges.
- R9: The match is only evaluated in the cycle after a capture. Writing a compare value equal to an older capture does not set irq_o.
- R10: Writes to address 2 (capture, read-only) and address 3 (live count, read-only) change neither value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timing enable; advances the counter by one |
| bus_i | input | 1 | Single-wire bus level, idle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 compare, 1 control, 2 capture, 3 count |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 16 | Combinational read data |
| capture_o | output | 16 | Last captured count |
| irq_o | output | 1 | Sticky compare-match interrupt |
| irq_clr_i | input | 1 | Clears the interrupt flag |

## Verification
The assertions check the counter step and hold, the capture load on each detected edge, the capture hold between edges, compare writes, flag stickiness and the rule that a rising flag needs the enable, an equal capture and a capture two cycles earlier. They check these on every clock. Only the bench's scenarios can show the end-to-end edge latency through the synchronizer, the wrap at 0xFFFF, a clear and a match landing on the same edge, and the absence of any flag when the compare value is changed to equal an older capture. Ignored writes to the read-only addresses are also shown only by the bench.

// File: rtl/ectm_pkg.sv
// Shared definitions for the bus-edge capture/compare timer.
// Assumes a four-entry register map addressed by a two-bit field.
package ectm_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CMP  = 2'd0,
        REG_CTRL = 2'd1,
        REG_CAP  = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ectm_bus_edge.sv
// Re-times the bus level through STAGES flops and flags a high-to-low change.
// Assumes the bus idles high, so all flops reset to one and no edge follows reset.
module ectm_bus_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_i,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw bus level.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= bus_i;
                end
            end else begin : g_next
                // Later stages shift the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Holds the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    // A falling edge is previous high with current low.
    assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/ectm_ticker.sv
// Free-running W-bit counter advanced by a timing enable.
// Assumes the enable is a single-cycle pulse in the system clock domain; wraps silently.
module ectm_ticker #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] count_q;

    // Steps the count once per enable, wrapping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (tick_i) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

endmodule

// File: rtl/ectm_match.sv
// Capture register, one-shot compare and sticky interrupt flag.
// Assumes fall_i is a single-cycle pulse; the compare runs only in the cycle after a capture.
module ectm_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_i,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] cmp_i,
    input  logic         en_i,
    input  logic         clr_i,
    output logic [W-1:0] cap_o,
    output logic         flag_o
);

    logic [W-1:0] cap_q;
    logic         fresh_q;
    logic         flag_q;
    logic         hit;

    // Loads the live count on every detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (fall_i) cap_q <= count_i;
    end

    // Marks the single cycle in which a new capture may be compared.
    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= fall_i;
    end

    assign hit = fresh_q & en_i & (cap_q == cmp_i);

    // Sticky flag: a match sets it, the clear strobe drops it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign cap_o  = cap_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/ectm_ctrl_regs.sv
// Compare value and enable storage plus the read-back multiplexer.
// Assumes capture and count are read-only; writes to their addresses are dropped.
module ectm_ctrl_regs
    import ectm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [W-1:0]          wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    input  logic [W-1:0]          cap_i,
    input  logic [W-1:0]          count_i,
    output logic [W-1:0]          cmp_o,
    output logic                  en_o,
    output logic [W-1:0]          rd_data_o
);

    logic [W-1:0] cmp_q;
    logic         en_q;
    reg_sel_e     wsel;
    reg_sel_e     rsel;

    assign wsel = reg_sel_e'(wr_addr_i);
    assign rsel = reg_sel_e'(rd_addr_i);

    // Stores the compare value on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmp_q <= '0;
        else if (wr_en_i && wsel == REG_CMP) cmp_q <= wr_data_i;
    end

    // Stores the interrupt enable from bit 0 of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           en_q <= 1'b0;
        else if (wr_en_i && wsel == REG_CTRL) en_q <= wr_data_i[0];
    end

    // Selects the read-back value by address.
    always_comb begin
        unique case (rsel)
            REG_CMP:  rd_data_o = cmp_q;
            REG_CTRL: rd_data_o = {{(W-1){1'b0}}, en_q};
            REG_CAP:  rd_data_o = cap_i;
            REG_CNT:  rd_data_o = count_i;
            default:  rd_data_o = '0;
        endcase
    end

    assign cmp_o = cmp_q;
    assign en_o  = en_q;

endmodule

// File: rtl/edge_capture_timer.sv
// Top of the bus-edge capture/compare timer: wires the synchronizer, counter,
// capture/compare logic and register port together.
// Assumes tick_i and all register inputs are synchronous to clk; bus_i may be asynchronous.
module edge_capture_timer
    import ectm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  bus_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]      wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]      rd_data_o,
    output logic [CNT_W-1:0]      capture_o,
    output logic                  irq_o,
    input  logic                  irq_clr_i
);

    logic             fall;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp;
    logic             en;

    ectm_bus_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_i  (bus_i),
        .fall_o (fall)
    );

    ectm_ticker #(.W(CNT_W)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (count)
    );

    ectm_match #(.W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .count_i (count),
        .cmp_i   (cmp),
        .en_i    (en),
        .clr_i   (irq_clr_i),
        .cap_o   (capture_o),
        .flag_o  (irq_o)
    );

    ectm_ctrl_regs #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .cap_i     (capture_o),
        .count_i   (count),
        .cmp_o     (cmp),
        .en_o      (en),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/ectm_checker.sv
// Property checker for edge_capture_timer, attached with bind.
// Assumes the internal names fall, count, cmp and en of the top module.
module ectm_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_i,
    input logic         wr_en_i,
    input logic [1:0]   wr_addr_i,
    input logic [W-1:0] wr_data_i,
    input logic         irq_clr_i,
    input logic [W-1:0] capture_o,
    input logic         irq_o,
    input logic         fall,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp,
    input logic         en
);

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> count == W'($past(count) + 1'b1));

    assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> capture_o == $past(count));

    assert_cap_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(capture_o));

    assert_cmp_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 2'd0) |=> cmp == $past(wr_data_i));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(capture_o == cmp));

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(en));

    assert_irq_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(fall, 2));

endmodule

bind edge_capture_timer ectm_checker #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .irq_clr_i (irq_clr_i),
    .capture_o (capture_o),
    .irq_o     (irq_o),
    .fall      (fall),
    .count     (count),
    .cmp       (cmp),
    .en        (en)
);

// File: tb/sim_edge_capture_timer.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module sim_edge_capture_timer;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         bus_i = 1'b1;
    logic         wr_en_i = 1'b0;
    logic [1:0]   wr_addr_i = 2'd0;
    logic [W-1:0] wr_data_i = '0;
    logic [1:0]   rd_addr_i = 2'd0;
    logic [W-1:0] rd_data_o;
    logic [W-1:0] capture_o;
    logic         irq_o;
    logic         irq_clr_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_n = 0;
    int tick_mode = 1;
    int tdiv = 0;
    bit started = 0;

    edge_capture_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .bus_i     (bus_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .capture_o (capture_o),
        .irq_o     (irq_o),
        .irq_clr_i (irq_clr_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Timing enable: off, one in four cycles, or every cycle.
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        case (tick_mode)
            0:       tick_i = 1'b0;
            1:       tick_i = (tdiv == 0);
            default: tick_i = 1'b1;
        endcase
    end

    // Reference model state.
    logic [W-1:0] m_timer, m_cap, m_cmp;
    logic         m_en, m_flag, m_fresh;
    bit           bq[$];

    always @(posedge clk) begin
        bit fall_now;
        bit set_now;
        if (!rst_n) begin
            m_timer = '0; m_cap = '0; m_cmp = '0;
            m_en = 0; m_flag = 0; m_fresh = 0;
            bq = '{1'b1, 1'b1, 1'b1};
        end else begin
            fall_now = bq[2] && !bq[1];
            set_now  = m_fresh && m_en && (m_cap == m_cmp);
            if (set_now)        m_flag = 1'b1;
            else if (irq_clr_i) m_flag = 1'b0;
            m_fresh = fall_now;
            if (fall_now) m_cap = m_timer;
            if (wr_en_i && wr_addr_i == 2'd0) m_cmp = wr_data_i;
            if (wr_en_i && wr_addr_i == 2'd1) m_en = wr_data_i[0];
            if (tick_i) m_timer = m_timer + 1'b1;
            bq.push_front(bus_i);
            void'(bq.pop_back());
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        logic [W-1:0] exp_rd;
        if (rst_n) started = 1;
        if (started) begin
            case (rd_addr_i)
                2'd0: exp_rd = m_cmp;
                2'd1: exp_rd = {15'd0, m_en};
                2'd2: exp_rd = m_cap;
                default: exp_rd = m_timer;
            endcase
            chk("R3", "capture_o", capture_o, m_cap);
            chk("R6", "irq_o", irq_o, m_flag);
            chk(rd_addr_i == 2'd3 ? "R2" : (rd_addr_i == 2'd2 ? "R3" : "R5"),
                "rd_data_o", rd_data_o, exp_rd);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 190000) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        cyc(1);
        wr_en_i = 1'b0;
    endtask

    initial begin
        logic [W-1:0] t, t2, t3, c1, a;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd_addr_i = 2'd0; look();
        chk("R1", "capture after reset", capture_o, 16'h0);
        chk("R1", "irq after reset", irq_o, 1'b0);
        chk("R1", "compare after reset", rd_data_o, 16'h0);
        cyc(1); rd_addr_i = 2'd1; look();
        chk("R1", "enable after reset", rd_data_o, 16'h0);

        // R2 one step per tick at one-in-four rate
        cyc(1); rd_addr_i = 2'd3; look(); a = rd_data_o;
        cyc(8); look();
        chk("R2", "count after 8 cycles", rd_data_o, a + 16'd2);

        // R5 register writes and read-back
        cyc(1);
        wr(2'd0, 16'h1234); rd_addr_i = 2'd0; look();
        chk("R5", "compare readback", rd_data_o, 16'h1234);
        cyc(1);
        wr(2'd1, 16'hFFFF); rd_addr_i = 2'd1; look();
        chk("R5", "enable readback", rd_data_o, 16'h0001);
        cyc(1);

        // R3 pulses of several widths
        for (int w = 1; w <= 9; w += 4) begin
            bus_i = 1'b1; cyc(w + 3);
            bus_i = 1'b0; cyc(w + 4);
        end
        bus_i = 1'b1; cyc(6);

        // R6 frozen count, match on next capture
        tick_mode = 0; cyc(3);
        rd_addr_i = 2'd3; look(); t = rd_data_o;
        cyc(1);
        wr(2'd0, t); wr(2'd1, 16'h1);
        bus_i = 1'b1; cyc(4);
        bus_i = 1'b0; cyc(4); look();
        chk("R6", "irq after match", irq_o, 1'b1);
        chk("R3", "capture equals frozen count", capture_o, t);

        // R7 sticky, clear, then set beats clear
        cyc(5); look();
        chk("R7", "irq held without clear", irq_o, 1'b1);
        cyc(1); irq_clr_i = 1'b1; cyc(1); irq_clr_i = 1'b0; look();
        chk("R7", "irq cleared", irq_o, 1'b0);
        cyc(1);
        bus_i = 1'b1; cyc(4);
        bus_i = 1'b0; cyc(3);
        irq_clr_i = 1'b1; cyc(1); irq_clr_i = 1'b0; look();
        chk("R7", "set wins over clear", irq_o, 1'b1);
        cyc(1); irq_clr_i = 1'b1; cyc(1); irq_clr_i = 1'b0;

        // R8 enable clear: capture continues, no flag
        wr(2'd1, 16'h0);
        tick_mode = 1; cyc(20); tick_mode = 0; cyc(3);
        rd_addr_i = 2'd3; look(); t2 = rd_data_o;
        cyc(1);
        wr(2'd0, t2);
        bus_i = 1'b1; cyc(4);
        bus_i = 1'b0; cyc(6); look();
        chk("R8", "capture while disabled", capture_o, t2);
        chk("R8", "no irq while disabled", irq_o, 1'b0);

        // R9 later compare write equal to old capture
        cyc(1);
        wr(2'd1, 16'h1);
        bus_i = 1'b1; cyc(4);
        tick_mode = 1; cyc(10); tick_mode = 0; cyc(3);
        look(); t3 = rd_data_o;
        cyc(1);
        wr(2'd0, t3 ^ 16'h00FF);
        bus_i = 1'b0; cyc(6); look();
        chk("R9", "capture with mismatch", capture_o, t3);
        chk("R9", "no irq on mismatch", irq_o, 1'b0);
        cyc(1);
        wr(2'd0, t3); cyc(6); look();
        chk("R9", "no irq from late compare write", irq_o, 1'b0);

        // R10 read-only addresses ignore writes
        cyc(1);
        rd_addr_i = 2'd2;
        wr(2'd2, 16'hBEEF); look();
        chk("R10", "capture after write", rd_data_o, t3);
        cyc(1);
        rd_addr_i = 2'd3;
        wr(2'd3, 16'h0000); look();
        chk("R10", "count after write", rd_data_o, t3);

        // R4 rising edge, held high, held low
        cyc(1);
        tick_mode = 1; bus_i = 1'b1; cyc(8); look();
        chk("R4", "capture after rise", capture_o, t3);
        cyc(1); bus_i = 1'b0; cyc(6); look(); c1 = capture_o;
        cyc(30); look();
        chk("R4", "capture while held low", capture_o, c1);

        // R2 wrap with a tick every cycle
        cyc(1); bus_i = 1'b1; rd_addr_i = 2'd3; tick_mode = 2;
        for (int i = 0; i < 70000; i++) begin
            look();
            if (rd_data_o == 16'hFFFF) break;
        end
        look();
        chk("R2", "count wraps to zero", rd_data_o, 16'h0000);
        cyc(1); bus_i = 1'b0; cyc(6);
        tick_mode = 1; cyc(4);

        summary();
        $finish;
    end

endmodule